// File: doc/BRIEF.md
# Rename Register Pool with Linked Free and In-Flight Lists

This block owns a numbered set of rename registers that an out-of-order core uses as value names. Every entry carries a data word, a valid bit, an architectural-register tag and a link field. The link fields chain each unmapped entry into one of two singly linked lists. The free list supplies new value names. The in-flight list keeps allocated entries in issue order, so its head is always the next entry to commit. Each list keeps only a head pointer, a tail pointer and an empty flag. No separate queue storage exists.

Four operations can occur in the same cycle:

- **Allocate** pops the free head and appends it to the in-flight tail with a tag.
- **Writeback** stores a result and marks it valid one cycle later.
- **Retire** pops the in-flight head.
- **Release** returns an entry that is no longer needed to the free-list tail.

A combinational read port exposes the data and valid bit of any entry for operand lookup.

Top module: `rpool_top`

## Requirements
- R1: After reset, entries 0 to ARCH_REGS-1 are valid with data zero. Every other entry is invalid. The free list holds entries ARCH_REGS to NUM_REGS-1, so `alloc_id` shows ARCH_REGS and `free_empty` is 0. `inflight_empty` is 1.
- R2: When `alloc_req` is high and the free list is not empty, the entry named by `alloc_id` is handed out, and `alloc_id` then shows the next entry in list order. Entries from reset come out in ascending order.
- R3: On allocation, the valid bit of the allocated entry clears and its tag is written, both at the same clock edge.
- R4: `retire_id` and `retire_tag` show the oldest allocated entry that has not yet retired, together with the tag it was allocated with. Entries retire in allocation order.
- R5: A writeback presented in cycle t is not visible after the edge that ends cycle t. The data and a set valid bit appear on the read port after the following edge.
- R6: A released entry is appended at the free-list tail. It is handed out only after every entry that was already free.
- R7: An allocate request while the free list is empty changes nothing, and no entry enters the in-flight list. A retire request while the in-flight list is empty changes nothing, and the list stays empty.
- R8: A pop and a push on the same list in the same cycle both take effect. This includes the case where the list held a single entry: afterwards the list holds only the pushed entry.
- R9: Each empty flag is 1 exactly when its list holds no entry. A flag rises after the last pop and falls after the first push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request a new value name |
| alloc_tag | input | TAG_W | Architectural register for the new entry |
| alloc_id | output | ID_W | Current free-list head, which is the name handed out |
| free_empty | output | 1 | Free list holds no entry |
| wb_en | input | 1 | Writeback valid |
| wb_id | input | ID_W | Entry receiving the result |
| wb_data | input | DATA_W | Result value |
| retire_req | input | 1 | Pop the in-flight head |
| retire_id | output | ID_W | In-flight head entry |
| retire_tag | output | TAG_W | Tag of the in-flight head entry |
| inflight_empty | output | 1 | In-flight list holds no entry |
| rel_en | input | 1 | Return an entry to the free list |
| rel_id | input | ID_W | Entry being returned |
| rd_id | input | ID_W | Entry to look up |
| rd_data | output | DATA_W | Data of the looked-up entry |
| rd_valid | output | 1 | Valid bit of the looked-up entry |

## Verification
The list logic is driven with several patterns:

- **Ascending allocation from reset.** Checks that the links are initialised correctly.
- **Full drain after one release.** Shows whether a released entry goes to the tail or the head.
- **Requests on empty lists.** Checks that an ignored pop leaves no trace, which a later complete retirement sweep would expose.
- **Same-cycle pop and push on single-entry lists.** Separates correct head reloading from the stale-link case.

Writeback is sampled both one edge and two edges after it is presented. This separates a one-cycle delay from no delay or a lost write.

// File: rtl/rpool_pkg.sv
// Package: shared default sizes for the rename register pool.
// Assumes: users may override these at the top level.
package rpool_pkg;
    localparam int unsigned POOL_REGS = 16;
    localparam int unsigned POOL_ARCH = 4;
    localparam int unsigned POOL_DW   = 16;
endpackage

// File: rtl/rpool_list.sv
// Module: head/tail/empty control for one singly linked list.
// The links themselves live in the register array. This module only
// requests a link write when a push must chain behind the old tail.
// Assumes: push_id is not already a member of this list, and head_link
// is the stored link of the current head.
module rpool_list #(
    parameter int unsigned ID_W       = 4,
    parameter bit          INIT_EMPTY = 1'b1,
    parameter int unsigned INIT_HEAD  = 0,
    parameter int unsigned INIT_TAIL  = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    input  logic [ID_W-1:0] head_link,
    output logic [ID_W-1:0] head,
    output logic            empty,
    output logic            pop_ok,
    output logic            lk_we,
    output logic [ID_W-1:0] lk_addr,
    output logic [ID_W-1:0] lk_data
);
    logic [ID_W-1:0] tail;
    logic            last;

    // purpose: decide whether the pop is legal and whether this push needs a link write
    always_comb begin
        pop_ok  = pop && !empty;
        last    = (head == tail);
        lk_we   = push && !(empty || (pop_ok && last));
        lk_addr = tail;
        lk_data = push_id;
    end

    // purpose: update head, tail and empty for a push, a pop or both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= ID_W'(INIT_HEAD);
            tail  <= ID_W'(INIT_TAIL);
            empty <= INIT_EMPTY;
        end else if (push) begin
            tail  <= push_id;
            empty <= 1'b0;
            if (empty || (pop_ok && last))
                head <= push_id;
            else if (pop_ok)
                head <= head_link;
        end else if (pop_ok) begin
            if (last)
                empty <= 1'b1;
            else
                head <= head_link;
        end
    end

    p_push_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (tail == $past(push_id)) && !empty);
    p_pop_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && head != tail && !push) |=> head == $past(head_link));
    p_empty_pop_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty && $stable(head));
    p_last_pop_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && head == tail && !push) |=> empty);
endmodule

// File: rtl/rpool_wb_stage.sv
// Module: one-cycle delay for writeback results before they reach the array.
// Assumes: at most one writeback per cycle.
module rpool_wb_stage #(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_en,
    output logic [ID_W-1:0]   out_id,
    output logic [DATA_W-1:0] out_data
);
    // purpose: hold the presented result for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en   <= 1'b0;
            out_id   <= '0;
            out_data <= '0;
        end else begin
            out_en   <= in_en;
            out_id   <= in_id;
            out_data <= in_data;
        end
    end

    p_stage_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_en |=> out_en && out_id == $past(in_id));
endmodule

// File: rtl/rpool_regs.sv
// Module: per-entry storage for data, valid bit, architectural tag and link.
// At reset, entries below ARCH_REGS hold the committed mappings, and the
// remaining entries are chained in ascending order.
// Assumes: the two link write ports never target the same entry, and an
// allocation overrides a delayed writeback to the same entry.
module rpool_regs #(
    parameter int unsigned NUM_REGS  = 16,
    parameter int unsigned ARCH_REGS = 4,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ID_W      = 4,
    parameter int unsigned TAG_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_en,
    input  logic [ID_W-1:0]   w_id,
    input  logic [DATA_W-1:0] w_data,
    input  logic              al_en,
    input  logic [ID_W-1:0]   al_id,
    input  logic [TAG_W-1:0]  al_tag,
    input  logic              lka_we,
    input  logic [ID_W-1:0]   lka_addr,
    input  logic [ID_W-1:0]   lka_data,
    input  logic              lkb_we,
    input  logic [ID_W-1:0]   lkb_addr,
    input  logic [ID_W-1:0]   lkb_data,
    input  logic [ID_W-1:0]   ra_id,
    output logic [ID_W-1:0]   ra_link,
    input  logic [ID_W-1:0]   rb_id,
    output logic [ID_W-1:0]   rb_link,
    output logic [TAG_W-1:0]  rb_tag,
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] data_q  [NUM_REGS];
    logic              valid_q [NUM_REGS];
    logic [TAG_W-1:0]  tag_q   [NUM_REGS];
    logic [ID_W-1:0]   link_q  [NUM_REGS];

    // purpose: reset the contents and apply writeback, allocation and link writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NUM_REGS); i++) begin
                data_q[i]  <= '0;
                valid_q[i] <= (i < int'(ARCH_REGS));
                tag_q[i]   <= (i < int'(ARCH_REGS)) ? TAG_W'(i) : '0;
                link_q[i]  <= ID_W'(i + 1);
            end
        end else begin
            if (w_en) begin
                data_q[w_id]  <= w_data;
                valid_q[w_id] <= 1'b1;
            end
            if (al_en) begin
                valid_q[al_id] <= 1'b0;
                tag_q[al_id]   <= al_tag;
            end
            if (lka_we) link_q[lka_addr] <= lka_data;
            if (lkb_we) link_q[lkb_addr] <= lkb_data;
        end
    end

    // purpose: combinational read ports
    always_comb begin
        ra_link  = link_q[ra_id];
        rb_link  = link_q[rb_id];
        rb_tag   = tag_q[rb_id];
        rd_data  = data_q[rd_id];
        rd_valid = valid_q[rd_id];
    end

    p_wb_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_en && !(al_en && al_id == w_id)) |=> valid_q[$past(w_id)]);
    p_alloc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        al_en |=> !valid_q[$past(al_id)] && tag_q[$past(al_id)] == $past(al_tag));
    p_link_ports_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (lka_we && lkb_we) |-> lka_addr != lkb_addr);
endmodule

// File: rtl/rpool_top.sv
// Module: rename register pool. The free list and the in-flight list
// share one link array. Allocation moves the free head to the in-flight
// tail, release pushes onto the free tail, retire pops the in-flight head.
// Assumes: a released entry is in neither list, and writeback targets an
// allocated entry.
module rpool_top
    import rpool_pkg::*;
#(
    parameter int unsigned NUM_REGS  = POOL_REGS,
    parameter int unsigned ARCH_REGS = POOL_ARCH,
    parameter int unsigned DATA_W    = POOL_DW,
    localparam int unsigned ID_W     = $clog2(NUM_REGS),
    localparam int unsigned TAG_W    = (ARCH_REGS > 1) ? $clog2(ARCH_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic [ID_W-1:0]   alloc_id,
    output logic              free_empty,
    input  logic              wb_en,
    input  logic [ID_W-1:0]   wb_id,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              retire_req,
    output logic [ID_W-1:0]   retire_id,
    output logic [TAG_W-1:0]  retire_tag,
    output logic              inflight_empty,
    input  logic              rel_en,
    input  logic [ID_W-1:0]   rel_id,
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              alloc_fire, retire_fire;
    logic [ID_W-1:0]   free_link, inf_link;
    logic              f_we, i_we;
    logic [ID_W-1:0]   f_addr, f_data, i_addr, i_data;
    logic              wq_en;
    logic [ID_W-1:0]   wq_id;
    logic [DATA_W-1:0] wq_data;

    rpool_list #(.ID_W(ID_W), .INIT_EMPTY(ARCH_REGS >= NUM_REGS),
                 .INIT_HEAD(ARCH_REGS), .INIT_TAIL(NUM_REGS - 1)) u_free (
        .clk(clk), .rst_n(rst_n), .push(rel_en), .push_id(rel_id),
        .pop(alloc_req), .head_link(free_link), .head(alloc_id),
        .empty(free_empty), .pop_ok(alloc_fire),
        .lk_we(f_we), .lk_addr(f_addr), .lk_data(f_data));

    rpool_list #(.ID_W(ID_W), .INIT_EMPTY(1'b1),
                 .INIT_HEAD(0), .INIT_TAIL(0)) u_infl (
        .clk(clk), .rst_n(rst_n), .push(alloc_fire), .push_id(alloc_id),
        .pop(retire_req), .head_link(inf_link), .head(retire_id),
        .empty(inflight_empty), .pop_ok(retire_fire),
        .lk_we(i_we), .lk_addr(i_addr), .lk_data(i_data));

    rpool_wb_stage #(.ID_W(ID_W), .DATA_W(DATA_W)) u_wb (
        .clk(clk), .rst_n(rst_n), .in_en(wb_en), .in_id(wb_id),
        .in_data(wb_data), .out_en(wq_en), .out_id(wq_id), .out_data(wq_data));

    rpool_regs #(.NUM_REGS(NUM_REGS), .ARCH_REGS(ARCH_REGS), .DATA_W(DATA_W),
                 .ID_W(ID_W), .TAG_W(TAG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .w_en(wq_en), .w_id(wq_id), .w_data(wq_data),
        .al_en(alloc_fire), .al_id(alloc_id), .al_tag(alloc_tag),
        .lka_we(f_we), .lka_addr(f_addr), .lka_data(f_data),
        .lkb_we(i_we), .lkb_addr(i_addr), .lkb_data(i_data),
        .ra_id(alloc_id), .ra_link(free_link),
        .rb_id(retire_id), .rb_link(inf_link), .rb_tag(retire_tag),
        .rd_id(rd_id), .rd_data(rd_data), .rd_valid(rd_valid));

    p_alloc_enters_infl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> !inflight_empty);
    p_empty_alloc_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && free_empty && !retire_req) |=> $stable(inflight_empty) && $stable(retire_id));
    p_retire_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_fire && alloc_fire) |=> !inflight_empty);
endmodule

// File: tb/rpool_top_bench.sv
module rpool_top_bench;
    localparam int ID_W = 4, TAG_W = 2, DATA_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_req = 0, wb_en = 0, retire_req = 0, rel_en = 0;
    logic [TAG_W-1:0]  alloc_tag = '0;
    logic [ID_W-1:0]   wb_id = '0, rel_id = '0, rd_id = '0;
    logic [DATA_W-1:0] wb_data = '0;
    logic [ID_W-1:0]   alloc_id, retire_id;
    logic [TAG_W-1:0]  retire_tag;
    logic free_empty, inflight_empty, rd_valid;
    logic [DATA_W-1:0] rd_data;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rpool_top u_rpool_top (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_tag(alloc_tag),
        .alloc_id(alloc_id), .free_empty(free_empty), .wb_en(wb_en), .wb_id(wb_id),
        .wb_data(wb_data), .retire_req(retire_req), .retire_id(retire_id),
        .retire_tag(retire_tag), .inflight_empty(inflight_empty), .rel_en(rel_en),
        .rel_id(rel_id), .rd_id(rd_id), .rd_data(rd_data), .rd_valid(rd_valid));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: inputs held for the cycle, then cleared just after the edge
    task automatic tick();
        @(posedge clk); #1;
        alloc_req = 0; retire_req = 0; rel_en = 0; wb_en = 0;
    endtask

    task automatic t_reset();
        chk("R1 free head", alloc_id, 4);
        chk("R1 free_empty", free_empty, 0);
        chk("R1 inflight_empty", inflight_empty, 1);
        for (int i = 0; i < 5; i++) begin
            rd_id = ID_W'(i); #1;
            chk("R1 valid", rd_valid, i < 4);
            if (i < 4) chk("R1 data", rd_data, 0);
        end
    endtask

    task automatic t_alloc();
        for (int i = 0; i < 3; i++) begin
            chk("R2 alloc id", alloc_id, 4 + i);
            alloc_req = 1; alloc_tag = TAG_W'(i + 1); tick();
        end
        chk("R2 next head", alloc_id, 7);
        rd_id = 4; #1;
        chk("R3 valid cleared", rd_valid, 0);
        chk("R4 head id", retire_id, 4);
        chk("R4 head tag", retire_tag, 1);
        chk("R9 inflight nonempty", inflight_empty, 0);
    endtask

    task automatic t_wb();
        wb_en = 1; wb_id = 5; wb_data = 16'hABCD; tick();
        rd_id = 5; #1;
        chk("R5 not yet valid", rd_valid, 0);
        tick(); #1;
        chk("R5 valid", rd_valid, 1);
        chk("R5 data", rd_data, 16'hABCD);
    endtask

    task automatic t_retire();
        for (int i = 0; i < 3; i++) begin
            chk("R4 retire id", retire_id, 4 + i);
            chk("R4 retire tag", retire_tag, i + 1);
            retire_req = 1; tick();
        end
        chk("R9 inflight empty", inflight_empty, 1);
        retire_req = 1; tick();
        chk("R7 retire on empty", inflight_empty, 1);
        chk("R7 free head kept", alloc_id, 7);
    endtask

    task automatic t_drain();
        rel_en = 1; rel_id = 2; tick();
        for (int i = 0; i < 10; i++) begin
            chk("R6 drain order", alloc_id, (i < 9) ? 7 + i : 2);
            alloc_req = 1; alloc_tag = TAG_W'(i); tick();
        end
        chk("R9 free empty", free_empty, 1);
        alloc_req = 1; alloc_tag = 3; tick();
        chk("R7 alloc on empty", free_empty, 1);
        for (int i = 0; i < 10; i++) begin
            chk("R4 drain retire", retire_id, (i < 9) ? 7 + i : 2);
            chk("R4 drain tag", retire_tag, i % 4);
            retire_req = 1; tick();
        end
        chk("R7 nothing extra", inflight_empty, 1);
    endtask

    task automatic t_simul();
        rel_en = 1; rel_id = 9; tick();
        chk("R9 free refilled", free_empty, 0);
        chk("R6 head after push", alloc_id, 9);
        alloc_req = 1; alloc_tag = 1; rel_en = 1; rel_id = 3; tick();
        chk("R8 free head", alloc_id, 3);
        chk("R8 free nonempty", free_empty, 0);
        chk("R8 inflight head", retire_id, 9);
        alloc_req = 1; alloc_tag = 2; retire_req = 1; tick();
        chk("R8 inflight head after swap", retire_id, 3);
        chk("R8 inflight tag", retire_tag, 2);
        chk("R8 inflight nonempty", inflight_empty, 0);
        chk("R9 free emptied", free_empty, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_alloc();
        t_wb();
        t_retire();
        t_drain();
        t_simul();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule